// File: doc/BRIEF.md
# Pulse-Width Sync/Data Stream Demultiplexer

This block takes one serial line that carries two kinds of active-low pulses: short sync pulses, and longer data pulses that belong to several time-multiplexed frequency channels. A fast system clock oversamples the line. Each falling edge starts a fixed one-shot timer, and the line is sampled once when the timer ends. A line that has already returned high marks a sync pulse. A line that is still low marks a data pulse. Each sync pulse produces a short active-low pulse on a rebuilt clock output. Data pulses produce nothing on that output.

A digital period counter measures the spacing between sync pulses. Once two successive spacings agree, it declares lock and issues four phase strobes at the quarter points of the measured period. On each strobe the block samples the line into the bit output of the matching channel. It also counts the low samples of each channel over a programmable number of sync pulses. Each channel's frequency therefore comes out as a ratio against the rebuilt clock, so the transmitter's timebase does not need to be accurate.

Top module: `pulse_stream_demux`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `rclk_n` is 1, `phase` is 0, `locked` is 0, `chan_valid` is 0, `chan_count` is all zeros and `chan_bit` is all ones.
- R2: The line passes through a two-flop synchroniser. A low level first sampled at clock edge n is classed at edge n+ONESHOT_LEN+2. For a sync pulse, `rclk_n` goes low at that edge.
- R3: A low pulse that spans W sampling edges is a sync pulse when W <= ONESHOT_LEN and a data pulse when W > ONESHOT_LEN. A data pulse leaves `rclk_n` high.
- R4: Each sync pulse drives `rclk_n` low for exactly two clock cycles.
- R5: A falling edge that arrives while the one-shot is running starts no new timing and produces no extra `rclk_n` pulse.
- R6: A sync period is the number of cycles between two classified sync pulses. `locked` rises at a sync pulse whose measured period equals the one before it. It falls at a sync pulse whose period differs. It therefore first rises at the third sync pulse after reset.
- R7: Let D be the edge at which `rclk_n` falls and P the latest measured period. While locked, `phase[i]` (i = 0..3) is a one-cycle strobe that rises at edge D+2+floor(i*P/4). At most one bit of `phase` is high at a time, and all bits stay 0 while unlocked.
- R8: At the edge where `phase[i]` rises, `chan_bit[i]` takes the line level that was present at edge D+floor(i*P/4). Here 1 means high and 0 means a pulse is present.
- R9: For each channel, the block counts the phase samples that see a low line. At every `win_len`-th sync pulse (a value of 0 acts as 1), the count is copied into `chan_count` field i (bits i*CNT_W upward) at edge D+1 and then restarts. `chan_valid` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the line |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Multiplexed sync/data pulse line, idle high |
| win_len | input | WIN_W | Sync pulses per counting window |
| rclk_n | output | 1 | Rebuilt clock, two-cycle active-low pulse per sync |
| phase | output | 4 | Quarter-period phase strobes |
| locked | output | 1 | Period tracker is locked |
| chan_bit | output | 4 | Per-channel sampled line level |
| chan_count | output | 4*CNT_W | Latched per-channel pulse counts |
| chan_valid | output | 1 | One-cycle strobe when chan_count updates |

## Verification
The bench builds the block with ONESHOT_LEN=6, PER_W=10, CNT_W=8 and WIN_W=4. A six-cycle one-shot puts the classification boundary between a six-cycle and a seven-cycle low pulse, so both sides can be driven directly. A 60-cycle frame gives quarter points of 0, 15, 30 and 45 cycles, each with room for a seven-cycle data pulse. With a window of four sync pulses, the first two windows close within eight frames. A shortened frame then breaks the period match and drops lock.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int N_PHASE = 4;
  localparam int Q_SHIFT = 2;
endpackage

// File: rtl/psd_in_sync.sv
module psd_in_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic s1, s2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
    end else begin
      s1   <= line_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign line_s = s2;
  assign fall   = prev & ~s2;
endmodule

// File: rtl/psd_width_class.sv
module psd_width_class #(
  parameter int ONESHOT_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic line_s,
  input  logic fall,
  output logic sync_evt,
  output logic rclk_n
);
  localparam int TW = $clog2(ONESHOT_LEN + 1);

  logic          busy;
  logic          hold;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      hold     <= 1'b0;
      tmr      <= '0;
      sync_evt <= 1'b0;
      rclk_n   <= 1'b1;
    end else begin
      sync_evt <= 1'b0;
      // extend the rebuilt-clock low pulse to two cycles
      if (hold) hold <= 1'b0;
      else      rclk_n <= 1'b1;
      if (busy) begin
        if (tmr == '0) begin
          busy <= 1'b0;
          if (line_s) begin
            sync_evt <= 1'b1;
            rclk_n   <= 1'b0;
            hold     <= 1'b1;
          end
        end else begin
          tmr <= tmr - 1'b1;
        end
      end else if (fall) begin
        busy <= 1'b1;
        tmr  <= TW'(ONESHOT_LEN - 1);
      end
    end
  end
endmodule

// File: rtl/psd_phase_lock.sv
module psd_phase_lock
  import psd_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_evt,
  output logic               locked,
  output logic [N_PHASE-1:0] ph_hit,
  output logic [N_PHASE-1:0] phase_q
);
  logic [PER_W-1:0] cyc;
  logic [PER_W-1:0] period_q;
  logic [PER_W-1:0] meas;
  logic [1:0]       n_ev;

  assign meas = cyc + 1'b1;

  for (genvar gi = 0; gi < N_PHASE; gi++) begin : g_quarter
    logic [PER_W+1:0] q;
    assign q = ({2'b00, period_q} * (PER_W+2)'(gi)) >> Q_SHIFT;
    assign ph_hit[gi] = locked && ({2'b00, cyc} == q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc      <= '0;
      period_q <= '0;
      n_ev     <= '0;
      locked   <= 1'b0;
      phase_q  <= '0;
    end else begin
      phase_q <= ph_hit;
      if (sync_evt) begin
        cyc      <= '0;
        period_q <= meas;
        if (n_ev != 2'd2) n_ev <= n_ev + 1'b1;
        else              locked <= (meas == period_q);
      end else if (cyc != '1) begin
        cyc <= cyc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/psd_chan_ratio.sv
module psd_chan_ratio
  import psd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WIN_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       line_s,
  input  logic                       sync_evt,
  input  logic [N_PHASE-1:0]         ph_hit,
  input  logic [WIN_W-1:0]           win_len,
  output logic [N_PHASE-1:0]         chan_bit,
  output logic [N_PHASE*CNT_W-1:0]   chan_count,
  output logic                       chan_valid
);
  logic [WIN_W-1:0] win_cnt;
  logic             win_end;

  assign win_end = sync_evt && (({1'b0, win_cnt} + 1'b1) >= {1'b0, win_len});

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt    <= '0;
      chan_valid <= 1'b0;
    end else begin
      chan_valid <= win_end;
      if (win_end)       win_cnt <= '0;
      else if (sync_evt) win_cnt <= win_cnt + 1'b1;
    end
  end

  for (genvar gc = 0; gc < N_PHASE; gc++) begin : g_chan
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    assign nxt = cnt + CNT_W'(ph_hit[gc] && !line_s);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt                          <= '0;
        chan_bit[gc]                 <= 1'b1;
        chan_count[gc*CNT_W +: CNT_W] <= '0;
      end else begin
        if (ph_hit[gc]) chan_bit[gc] <= line_s;
        if (win_end) begin
          chan_count[gc*CNT_W +: CNT_W] <= nxt;
          cnt                          <= '0;
        end else begin
          cnt <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_stream_demux.sv
module pulse_stream_demux
  import psd_pkg::*;
#(
  parameter int ONESHOT_LEN = 16,
  parameter int PER_W       = 12,
  parameter int CNT_W       = 16,
  parameter int WIN_W       = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     line_in,
  input  logic [WIN_W-1:0]         win_len,
  output logic                     rclk_n,
  output logic [N_PHASE-1:0]       phase,
  output logic                     locked,
  output logic [N_PHASE-1:0]       chan_bit,
  output logic [N_PHASE*CNT_W-1:0] chan_count,
  output logic                     chan_valid
);
  logic line_s, fall, sync_evt;
  logic [N_PHASE-1:0] ph_hit;

  psd_in_sync u_sync (
    .clk(clk), .rst(rst), .line_in(line_in), .line_s(line_s), .fall(fall)
  );

  psd_width_class #(.ONESHOT_LEN(ONESHOT_LEN)) u_class (
    .clk(clk), .rst(rst), .line_s(line_s), .fall(fall),
    .sync_evt(sync_evt), .rclk_n(rclk_n)
  );

  psd_phase_lock #(.PER_W(PER_W)) u_lock (
    .clk(clk), .rst(rst), .sync_evt(sync_evt),
    .locked(locked), .ph_hit(ph_hit), .phase_q(phase)
  );

  psd_chan_ratio #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_ratio (
    .clk(clk), .rst(rst), .line_s(line_s), .sync_evt(sync_evt),
    .ph_hit(ph_hit), .win_len(win_len), .chan_bit(chan_bit),
    .chan_count(chan_count), .chan_valid(chan_valid)
  );
endmodule

// File: rtl/pulse_stream_demux_chk.sv
module pulse_stream_demux_chk
  import psd_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               rclk_n,
  input logic [N_PHASE-1:0] phase,
  input logic               locked,
  input logic               chan_valid
);
  // R4: rebuilt clock low pulse lasts exactly two cycles
  a_r4_low_two_cycles: assert property (@(posedge clk) disable iff (rst)
    $fell(rclk_n) |=> !rclk_n ##1 rclk_n);

  // R7: strobes only follow a locked cycle
  a_r7_phase_needs_lock: assert property (@(posedge clk) disable iff (rst)
    (phase != '0) |-> $past(locked));

  // R7: never two phases at once
  a_r7_phase_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phase));

  // R9: valid strobe is a single cycle
  a_r9_valid_single: assert property (@(posedge clk) disable iff (rst)
    chan_valid |=> !chan_valid);

  // R4: no phase strobe coincides with the rebuilt clock falling
  a_r4_fall_no_phase: assert property (@(posedge clk) disable iff (rst)
    $fell(rclk_n) |-> (phase == '0));
endmodule

bind pulse_stream_demux pulse_stream_demux_chk u_chk (
  .clk(clk), .rst(rst), .rclk_n(rclk_n), .phase(phase),
  .locked(locked), .chan_valid(chan_valid)
);

// File: tb/pulse_stream_demux_tb.sv
module pulse_stream_demux_tb;
  localparam int OS = 6, PER_W = 10, CNT_W = 8, WIN_W = 4, P = 60;

  logic clk = 1'b0, rst = 1'b1, line_in = 1'b1;
  logic [WIN_W-1:0] win_len = 4'd4;
  logic rclk_n, locked, chan_valid;
  logic [3:0] phase, chan_bit;
  logic [4*CNT_W-1:0] chan_count;
  logic [3:0] en_tab [0:11];
  int checks = 0, fails = 0;

  pulse_stream_demux #(.ONESHOT_LEN(OS), .PER_W(PER_W), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_dut (
    .clk(clk), .rst(rst), .line_in(line_in), .win_len(win_len), .rclk_n(rclk_n),
    .phase(phase), .locked(locked), .chan_bit(chan_bit),
    .chan_count(chan_count), .chan_valid(chan_valid)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; line_in = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rclk_n", rclk_n, 1);
    chk("R1 phase", phase, 0);
    chk("R1 locked", locked, 0);
    chk("R1 chan_valid", chan_valid, 0);
    chk("R1 chan_count", (chan_count == '0) ? 0 : 1, 0);
    chk("R1 chan_bit", chan_bit, 15);
    repeat (4) @(negedge clk);
  endtask

  // low for w cycles, then optional second low of w2 after gap g
  task automatic t_pulse(input string req, input int w, input int g, input int w2,
                         input int exp_low, input int exp_first);
    int nlow = 0, first = -1;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (!rclk_n) begin
        nlow++;
        if (first < 0) first = j;
      end
      line_in = !(j < w || (w2 > 0 && j >= w + g && j < w + g + w2));
    end
    chk({req, " low cycles"}, nlow, exp_low);
    chk({req, " first low"}, first, exp_first);
  endtask

  task automatic t_frames();
    do_reset();
    en_tab[0] = 4'h0; en_tab[1] = 4'hF; en_tab[2] = 4'h5; en_tab[3] = 4'hA;
    en_tab[4] = 4'hF; en_tab[5] = 4'h3; en_tab[6] = 4'h8; en_tab[7] = 4'h6;
    en_tab[8] = 4'h1; en_tab[9] = 4'h9; en_tab[10] = 4'h0; en_tab[11] = 4'h0;
    for (int k = 1; k <= 11; k++) begin
      int len = (k == 10) ? 30 : P;
      int ph_err = 0, bit_err = 0, rk_err = 0;
      for (int j = 0; j < len; j++) begin
        logic lvl;
        @(negedge clk);
        if ((j == 9 || j == 10) && rclk_n !== 1'b0) rk_err++;
        if (j == 11 && rclk_n !== 1'b1) rk_err++;
        if (k >= 3 && k <= 9) begin
          for (int i = 0; i < 4; i++) begin
            logic e;
            e = (j == 11 + (P * i) / 4);
            if (phase[i] !== e) ph_err++;
            if (e && chan_bit[i] !== ~en_tab[k][i]) bit_err++;
          end
        end
        if (j == 12 && k == 2)  chk("R6 not locked after two syncs", locked, 0);
        if (j == 12 && k == 3)  chk("R6 locked at third sync", locked, 1);
        if (j == 12 && k == 11) chk("R6 lock dropped on period change", locked, 0);
        if (j == 10 && (k == 4 || k == 8)) begin
          chk("R9 valid at window end", chan_valid, 1);
          for (int i = 0; i < 4; i++) begin
            int exp = 0;
            for (int f = (k - 4 < 3 ? 3 : k - 4); f < k; f++) exp += en_tab[f][i];
            chk($sformatf("R9 count ch%0d", i), chan_count[i*CNT_W +: CNT_W], exp);
          end
        end
        if (j == 11 && (k == 4 || k == 8)) chk("R9 valid one cycle", chan_valid, 0);
        lvl = !(j < 2);
        for (int i = 0; i < 4; i++)
          if (en_tab[k][i] && j >= 7 + (P * i) / 4 && j <= 13 + (P * i) / 4) lvl = 1'b0;
        line_in = lvl;
      end
      chk($sformatf("R4 rclk pulse frame %0d", k), rk_err, 0);
      if (k >= 3 && k <= 9) begin
        chk($sformatf("R7 phase timing frame %0d", k), ph_err, 0);
        chk($sformatf("R8 channel bits frame %0d", k), bit_err, 0);
      end
    end
  endtask

  initial begin
    t_reset();
    t_pulse("R2 R4 short pulse", 2, 0, 0, 2, 9);
    t_pulse("R3 width at limit", OS, 0, 0, 2, 9);
    t_pulse("R3 width over limit", OS + 1, 0, 0, 0, -1);
    t_pulse("R5 edge during one-shot", 2, 2, 2, 2, 9);
    t_frames();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule